// File: doc/BRIEF.md
# Activation Group Canonicalizer

This block takes a group of `G` low-bit activations, each `AW` bits wide, and turns it into the two keys a packed lookup-table engine needs. The group is stably sorted into non-decreasing order, so every rearrangement of the same values collapses onto one representative. The sorted multiset is then ranked into a dense column number for a table that stores one column per multiset. The block also reports which rearrangement the sort applied, as a compact permutation number, so that the matching packed weights can be reordered in exactly the same way.

Groups arrive on a valid/ready stream and leave as (column, permutation) pairs on a second valid/ready stream. Inside, an odd-even transposition network of `G` registered stages sorts each group, and one more registered stage computes the rank and the permutation number. The pipeline accepts one group per cycle. When the consumer stalls, the whole pipeline stalls.

Top module: `act_group_canon`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Any two groups that hold the same multiset of values produce the same `out_col`, whatever order the values arrive in. Element k of the group is `in_data[k*AW +: AW]`.
- R3: Let s0 <= s1 <= ... be the sorted values. Then `out_col` = sum over i of C(s_i + i, i + 1). Its range is 0 to C(2^AW + G - 1, G) - 1. An all-zero group gives 0 and an all-maximum group gives the top value of that range.
- R4: Let p_i be the input position of the element placed at sorted position i. Then `out_perm` = sum over i of L_i * (G-1-i)!, where L_i counts the positions j > i with p_j < p_i. An input that is already in non-decreasing order gives 0. A strictly decreasing input gives G! - 1.
- R5: The sort is stable: equal values keep their input order. A group of all-equal values therefore gives `out_perm` = 0, and ties between equal values are resolved the same way every time.
- R6: With `out_ready` held at 1, a group accepted on a clock edge appears on the output G+1 edges later. A new group can be accepted every cycle. At most G+1 groups are ever in flight.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output values stay the same and `in_ready` is 0. No group is lost, and results leave in the order their groups were accepted.
- R8: `out_perm` is always below G!.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Block can take a group this cycle |
| in_data | input | G*AW | Packed activation group; element k at bits k*AW upward |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_col | output | CIW | Multiset column index |
| out_perm | output | PCW | Permutation number of the applied sort |

## Verification
A wrong compare-swap or a lost index tag in the sorting network shows up at the ports within G+1 cycles. It appears as a wrong column for a reordered input, or as a wrong permutation number, most visibly on tied values and on reversed groups. A fault in the stall logic shows up at the first cycle with back-pressure. A result would then change while it is held, be dropped or be duplicated, and the scoreboard order breaks on the next accepted result. A wrong stage count shifts every result's latency by whole cycles, and this is measured while the consumer never stalls.

// File: rtl/act_canon_pkg.sv
package act_canon_pkg;

  function automatic longint binom(input int n, input int k);
    longint r;
    r = 1;
    if (k < 0 || k > n) return 0;
    for (int i = 1; i <= k; i++) r = r * longint'(n - k + i) / longint'(i);
    return r;
  endfunction

  function automatic longint fact(input int n);
    longint r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * longint'(i);
    return r;
  endfunction

  function automatic int width_of(input longint count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/act_sort_net.sv
module act_sort_net
  import act_canon_pkg::*;
#(
  parameter int G  = 4,
  parameter int AW = 2,
  parameter int IW = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  in_valid,
  input  logic [G-1:0][AW-1:0]  in_vals,
  output logic                  out_valid,
  output logic [G-1:0][AW-1:0]  out_vals,
  output logic [G-1:0][IW-1:0]  out_idx
);

  logic [G-1:0][AW-1:0] st_v  [0:G-1];
  logic [G-1:0][IW-1:0] st_i  [0:G-1];
  logic                 st_q  [0:G-1];
  logic [G-1:0][AW-1:0] nx_v  [0:G-1];
  logic [G-1:0][IW-1:0] nx_i  [0:G-1];

  always_comb begin
    for (int s = 0; s < G; s++) begin
      if (s == 0) begin
        nx_v[s] = in_vals;
        for (int k = 0; k < G; k++) nx_i[s][k] = IW'(k);
      end else begin
        nx_v[s] = st_v[s-1];
        nx_i[s] = st_i[s-1];
      end
      for (int p = s % 2; p + 1 < G; p += 2) begin
        if (nx_v[s][p] > nx_v[s][p+1]) begin
          {nx_v[s][p], nx_v[s][p+1]} = {nx_v[s][p+1], nx_v[s][p]};
          {nx_i[s][p], nx_i[s][p+1]} = {nx_i[s][p+1], nx_i[s][p]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < G; s++) begin
      if (rst) begin
        st_q[s] <= 1'b0;
      end else if (en) begin
        st_q[s] <= (s == 0) ? in_valid : st_q[s-1];
        st_v[s] <= nx_v[s];
        st_i[s] <= nx_i[s];
      end
    end
  end

  assign out_valid = st_q[G-1];
  assign out_vals  = st_v[G-1];
  assign out_idx   = st_i[G-1];

endmodule

// File: rtl/act_rank_stage.sv
module act_rank_stage
  import act_canon_pkg::*;
#(
  parameter int G   = 4,
  parameter int AW  = 2,
  parameter int IW  = 2,
  parameter int CIW = 6,
  parameter int PCW = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  in_valid,
  input  logic [G-1:0][AW-1:0]  in_vals,
  input  logic [G-1:0][IW-1:0]  in_idx,
  output logic                  out_valid,
  output logic [CIW-1:0]        out_col,
  output logic [PCW-1:0]        out_perm
);

  localparam int V = 1 << AW;

  function automatic logic [G*V*CIW-1:0] build_rom();
    logic [G*V*CIW-1:0] r;
    r = '0;
    for (int i = 0; i < G; i++)
      for (int s = 0; s < V; s++)
        r[(i*V + s)*CIW +: CIW] = CIW'(binom(s + i, i + 1));
    return r;
  endfunction

  localparam logic [G*V*CIW-1:0] ROM = build_rom();

  logic [CIW-1:0] col_n;
  logic [PCW-1:0] perm_n;

  always_comb begin
    col_n  = '0;
    perm_n = '0;
    for (int i = 0; i < G; i++) begin
      int cnt;
      cnt = 0;
      for (int j = i + 1; j < G; j++)
        if (in_idx[j] < in_idx[i]) cnt++;
      perm_n = perm_n + PCW'(longint'(cnt) * fact(G - 1 - i));
      col_n  = col_n + ROM[(i*V + int'(in_vals[i]))*CIW +: CIW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
      out_col   <= col_n;
      out_perm  <= perm_n;
    end
  end

endmodule

// File: rtl/act_group_canon.sv
module act_group_canon
  import act_canon_pkg::*;
#(
  parameter int G   = 4,
  parameter int AW  = 2,
  localparam int V   = 1 << AW,
  localparam int IW  = width_of(longint'(G)),
  localparam int CIW = width_of(binom(V + G - 1, G)),
  localparam int PCW = width_of(fact(G))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [G*AW-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CIW-1:0]    out_col,
  output logic [PCW-1:0]    out_perm
);

  logic                 adv;
  logic                 srt_valid;
  logic [G-1:0][AW-1:0] srt_vals;
  logic [G-1:0][IW-1:0] srt_idx;

  assign adv      = ~out_valid | out_ready;
  assign in_ready = adv;

  act_sort_net #(.G(G), .AW(AW), .IW(IW)) u_sort (
    .clk(clk), .rst(rst), .en(adv),
    .in_valid(in_valid),
    .in_vals(in_data),
    .out_valid(srt_valid), .out_vals(srt_vals), .out_idx(srt_idx)
  );

  act_rank_stage #(.G(G), .AW(AW), .IW(IW), .CIW(CIW), .PCW(PCW)) u_rank (
    .clk(clk), .rst(rst), .en(adv),
    .in_valid(srt_valid), .in_vals(srt_vals), .in_idx(srt_idx),
    .out_valid(out_valid), .out_col(out_col), .out_perm(out_perm)
  );

endmodule

// File: rtl/act_canon_chk.sv
module act_canon_chk
  import act_canon_pkg::*;
#(
  parameter int G  = 4,
  parameter int AW = 2,
  localparam int V   = 1 << AW,
  localparam longint NCOL  = binom(V + G - 1, G),
  localparam longint NPERM = fact(G),
  localparam int CIW = width_of(NCOL),
  localparam int PCW = width_of(NPERM)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [CIW-1:0] out_col,
  input logic [PCW-1:0] out_perm
);

  int occ;

  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else occ <= occ + ((in_valid && in_ready) ? 1 : 0) - ((out_valid && out_ready) ? 1 : 0);
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_col) && $stable(out_perm)));

  p_block_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_col_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_col) < NCOL));

  p_perm_range_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_perm) < NPERM));

  p_occ_r6: assert property (@(posedge clk) disable iff (rst)
    (occ >= 0) && (occ <= G + 1));

endmodule

bind act_group_canon act_canon_chk #(.G(G), .AW(AW)) u_chk (.*);

// File: tb/sim_act_group_canon.sv
`timescale 1ns/100ps
module sim_act_group_canon;

  localparam int G   = 4;
  localparam int AW  = 2;
  localparam int V   = 1 << AW;
  localparam int CIW = 6;
  localparam int PCW = 5;

  typedef struct { int col; int perm; int cyc; } exp_t;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 1;
  logic [G*AW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [CIW-1:0] out_col;
  logic [PCW-1:0] out_perm;

  int tests = 0, fails = 0, cyc = 0;
  bit lat_check = 0, rdy_rand = 0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  act_group_canon u0 (.*);

  function automatic int nck(int n, int k);
    int r = 1;
    if (k < 0 || k > n) return 0;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  function automatic int fct(int n);
    int r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int v[G]);
    int p[G];
    int t;
    exp_t e;
    for (int i = 0; i < G; i++) p[i] = i;
    for (int i = 1; i < G; i++)
      for (int j = i; j > 0 && v[p[j-1]] > v[p[j]]; j--) begin
        t = p[j]; p[j] = p[j-1]; p[j-1] = t;
      end
    e.col = 0; e.perm = 0;
    for (int i = 0; i < G; i++) begin
      int l = 0;
      for (int j = i + 1; j < G; j++) if (p[j] < p[i]) l++;
      e.perm += l * fct(G - 1 - i);
      e.col  += nck(v[p[i]] + i, i + 1);
    end
    @(negedge clk);
    in_valid = 1;
    for (int i = 0; i < G; i++) in_data[i*AW +: AW] = AW'(v[i]);
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e.cyc = cyc;
    q.push_back(e);
    @(posedge clk);
    #0.5 in_valid = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      out_ready = rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (!rst && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R7 unexpected output", 1, 0);
        end else begin
          e = q.pop_front();
          check("R2/R3 col", int'(out_col), e.col);
          check("R4/R5 perm", int'(out_perm), e.perm);
          check("R8 perm range", int'(out_perm) < fct(G), 1);
          if (lat_check) check("R6 latency", cyc - e.cyc, G + 1);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    int v[G];
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);

    lat_check = 1;
    send('{0, 0, 0, 0});
    send('{3, 3, 3, 3});
    send('{0, 1, 2, 3});
    send('{3, 2, 1, 0});
    send('{2, 0, 2, 0});
    send('{1, 1, 1, 1});
    send('{3, 1, 0, 2});
    send('{2, 3, 1, 0});
    send('{0, 3, 2, 1});
    repeat (G + 4) @(posedge clk);

    // back-to-back acceptance with no stall: one group per cycle
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < G; i++) v[i] = $urandom_range(0, V - 1);
      send(v);
    end
    repeat (G + 4) @(posedge clk);

    lat_check = 0;
    rdy_rand  = 1;
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < G; i++) v[i] = $urandom_range(0, V - 1);
      send(v);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(posedge clk);
    end
    wait (q.size() == 0);
    repeat (4) @(posedge clk);
    check("R7 no lost result", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule